// File: doc/BRIEF.md
# Reconfigurable Slot Discovery Gatekeeper

This block sits between system software and one reconfigurable slot whose logic is not yet trusted. It keeps the slot's lifecycle state and controls every path from the slot to the memory bus while the slot is being discovered. The slot never drives the bus on its own. Software issues a register access, and the gatekeeper then opens a window onto the bus for that one transaction only. The window closes when the slot reports completion or when a programmable cycle budget runs out.

A timed-out access marks the slot as missing and raises a malfunction interrupt. The access then completes towards software with an all-ones data word. Software moves a present slot between its configuration, running and paused states with state commands. The slot's functional interfaces are enabled only while it is running. If the presence input drops, the slot becomes missing immediately.

Top module: `slot_gatekeeper`

## Requirements
- R1: After reset, `slotState` is Absent (code 0), and `busGrant`, `accDone`, `irqMalfunction` and `ifEnable` are all zero.
- R2: State codes are Absent=0, Config=1, Running=2, Suspended=3. A rising edge of `slotPresent` moves the state to Config, visible in the cycle after the edge is sampled.
- R3: A command (`cmdValid` with `cmdTarget`) is applied one cycle later only for these transitions: Config→Running, Running→Config, Running→Suspended and Suspended→Running. Every other target leaves the state unchanged.
- R4: `ifEnable` equals `reqIfMask` while the state is Running and is zero in every other state.
- R5: An access accepted at a clock edge raises `busGrant` in the next cycle. While the grant is high, `busAddr`, `busWdata` and `busWe` carry the accepted request. When no grant is high they are zero.
- R6: When `slotDone` is sampled high during a grant, the grant drops at that edge. `accDone` then pulses for one cycle, and `accRdata` holds the `slotRdata` value sampled at that edge.
- R7: Only one grant is outstanding at a time. `accReady` is low while a grant is high, and a request is accepted only while `accReady` is high.
- R8: If `slotDone` stays low for `timeoutLimit` grant cycles, the grant closes after exactly that many cycles. `accRdata` is then all ones, the state becomes Absent, and `irqMalfunction` pulses for one cycle together with `accDone`.
- R9: A `timeoutLimit` of zero selects the default budget of 64 grant cycles.
- R10: Loss of `slotPresent` forces Absent at the next edge and closes any open grant. The outstanding access completes with all ones, and `irqMalfunction` is not raised.
- R11: An access accepted while the slot is Absent opens no window. It completes in the next cycle with all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotPresent | input | 1 | Slot presence indication |
| timeoutLimit | input | TO_W | Grant cycle budget, 0 selects 64 |
| cmdValid | input | 1 | State command strobe |
| cmdTarget | input | 2 | Requested state code |
| reqIfMask | input | IF_W | Interfaces requested for the running state |
| accReq | input | 1 | Software register access request |
| accWe | input | 1 | Access is a write |
| accAddr | input | AW | Access register address |
| accWdata | input | DW | Access write data |
| accReady | output | 1 | No grant outstanding, request may be accepted |
| accDone | output | 1 | Access completion pulse |
| accRdata | output | DW | Access read result |
| busGrant | output | 1 | Slot may see the bus request |
| busWe | output | 1 | Gated write flag towards the slot |
| busAddr | output | AW | Gated address towards the slot |
| busWdata | output | DW | Gated write data towards the slot |
| slotDone | input | 1 | Slot completion signal |
| slotRdata | input | DW | Slot read data |
| ifEnable | output | IF_W | Functional interface enables |
| slotState | output | 2 | Lifecycle state code |
| irqMalfunction | output | 1 | Timeout interrupt pulse |

## Verification
A command or a presence edge appears on `slotState` one cycle after the edge that samples it. The grant rises one cycle after acceptance, and it falls at the same edge that samples `slotDone`, a timeout or loss of presence. `accDone`, `accRdata` and `irqMalfunction` change at that same edge. The bench drives inputs and samples outputs on the falling clock edge and counts grant cycles there. Every expected value is therefore read in the first half-cycle after the edge that produced it. Directed and random delays are chosen on both sides of the timeout budget, including the last cycle before it expires.

// File: rtl/slot_gate_pkg.sv
package slot_gate_pkg;
  typedef enum logic [1:0] {
    SLOT_ABSENT  = 2'd0,
    SLOT_CONFIG  = 2'd1,
    SLOT_RUNNING = 2'd2,
    SLOT_PAUSED  = 2'd3
  } slotState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic openWin;   // latch request, window opens next cycle
    logic closeOk;   // slot completed, capture its data
    logic closeFail; // timeout, abort or absent access: all ones
  } gateStrobe_t;
endpackage

// File: rtl/slot_gate_ctrl.sv
module slot_gate_ctrl
  import slot_gate_pkg::*;
#(
  parameter int TO_W        = 16,
  parameter int DEF_TIMEOUT = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            slotPresent,
  input  logic [TO_W-1:0] timeoutLimit,
  input  logic            cmdValid,
  input  logic [1:0]      cmdTarget,
  input  logic            accReq,
  input  logic            slotDone,
  output logic            busGrant,
  output logic            accReady,
  output slotState_e      stateQ,
  output logic            irqMalfunction,
  output gateStrobe_t     strobe
);
  localparam logic [TO_W-1:0] DefLimit = TO_W'(DEF_TIMEOUT);

  logic            grantQ;
  logic            presPrev;
  logic [TO_W-1:0] winCnt;
  logic [TO_W-1:0] effLimit;
  logic            accept, openOk, hit, expire, abort, cmdLegal;
  slotState_e      target;

  always_comb begin
    effLimit = (timeoutLimit == '0) ? DefLimit : timeoutLimit;
    accept   = accReq && !grantQ;
    openOk   = accept && slotPresent && (stateQ != SLOT_ABSENT);
    hit      = grantQ && slotPresent && slotDone;
    expire   = grantQ && slotPresent && !slotDone && (winCnt == effLimit - 1'b1);
    abort    = grantQ && !slotPresent;
    target   = slotState_e'(cmdTarget);
    unique case (stateQ)
      SLOT_CONFIG:  cmdLegal = (target == SLOT_RUNNING);
      SLOT_RUNNING: cmdLegal = (target == SLOT_CONFIG) || (target == SLOT_PAUSED);
      SLOT_PAUSED:  cmdLegal = (target == SLOT_RUNNING);
      default:      cmdLegal = 1'b0;
    endcase
    strobe.openWin   = openOk;
    strobe.closeOk   = hit;
    strobe.closeFail = expire || abort || (accept && !openOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ         <= SLOT_ABSENT;
      presPrev       <= 1'b0;
      grantQ         <= 1'b0;
      winCnt         <= '0;
      irqMalfunction <= 1'b0;
    end else begin
      presPrev       <= slotPresent;
      irqMalfunction <= expire;

      if (!slotPresent || expire)            stateQ <= SLOT_ABSENT;
      else if (!presPrev)                    stateQ <= SLOT_CONFIG;
      else if (cmdValid && cmdLegal)         stateQ <= target;

      if (openOk) begin
        grantQ <= 1'b1;
        winCnt <= '0;
      end else if (hit || expire || abort) begin
        grantQ <= 1'b0;
      end else if (grantQ) begin
        winCnt <= winCnt + 1'b1;
      end
    end
  end

  assign busGrant = grantQ;
  assign accReady = !grantQ;
endmodule

// File: rtl/slot_gate_dp.sv
module slot_gate_dp
  import slot_gate_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int IF_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  gateStrobe_t     strobe,
  input  logic            busGrant,
  input  slotState_e      stateQ,
  input  logic            accWe,
  input  logic [AW-1:0]   accAddr,
  input  logic [DW-1:0]   accWdata,
  input  logic [DW-1:0]   slotRdata,
  input  logic [IF_W-1:0] reqIfMask,
  output logic            accDone,
  output logic [DW-1:0]   accRdata,
  output logic            busWe,
  output logic [AW-1:0]   busAddr,
  output logic [DW-1:0]   busWdata,
  output logic [IF_W-1:0] ifEnable
);
  logic          reqWe;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] reqWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqWe    <= 1'b0;
      reqAddr  <= '0;
      reqWdata <= '0;
      accDone  <= 1'b0;
      accRdata <= '0;
    end else begin
      accDone <= strobe.closeOk || strobe.closeFail;
      if (strobe.openWin) begin
        reqWe    <= accWe;
        reqAddr  <= accAddr;
        reqWdata <= accWdata;
      end
      if (strobe.closeOk)        accRdata <= slotRdata;
      else if (strobe.closeFail) accRdata <= '1;
    end
  end

  always_comb begin
    busWe    = busGrant && reqWe;
    busAddr  = busGrant ? reqAddr : '0;
    busWdata = busGrant ? reqWdata : '0;
    ifEnable = (stateQ == SLOT_RUNNING) ? reqIfMask : '0;
  end
endmodule

// File: rtl/slot_gatekeeper.sv
module slot_gatekeeper
  import slot_gate_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 32,
  parameter int IF_W        = 4,
  parameter int TO_W        = 16,
  parameter int DEF_TIMEOUT = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            slotPresent,
  input  logic [TO_W-1:0] timeoutLimit,
  input  logic            cmdValid,
  input  logic [1:0]      cmdTarget,
  input  logic [IF_W-1:0] reqIfMask,
  input  logic            accReq,
  input  logic            accWe,
  input  logic [AW-1:0]   accAddr,
  input  logic [DW-1:0]   accWdata,
  output logic            accReady,
  output logic            accDone,
  output logic [DW-1:0]   accRdata,
  output logic            busGrant,
  output logic            busWe,
  output logic [AW-1:0]   busAddr,
  output logic [DW-1:0]   busWdata,
  input  logic            slotDone,
  input  logic [DW-1:0]   slotRdata,
  output logic [IF_W-1:0] ifEnable,
  output logic [1:0]      slotState,
  output logic            irqMalfunction
);
  gateStrobe_t strobe;
  slotState_e  stateQ;

  slot_gate_ctrl #(.TO_W(TO_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .slotPresent(slotPresent), .timeoutLimit(timeoutLimit),
    .cmdValid(cmdValid), .cmdTarget(cmdTarget), .accReq(accReq), .slotDone(slotDone),
    .busGrant(busGrant), .accReady(accReady), .stateQ(stateQ),
    .irqMalfunction(irqMalfunction), .strobe(strobe)
  );

  slot_gate_dp #(.AW(AW), .DW(DW), .IF_W(IF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busGrant(busGrant), .stateQ(stateQ),
    .accWe(accWe), .accAddr(accAddr), .accWdata(accWdata), .slotRdata(slotRdata),
    .reqIfMask(reqIfMask), .accDone(accDone), .accRdata(accRdata), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .ifEnable(ifEnable)
  );

  assign slotState = stateQ;
endmodule

// File: rtl/slot_gatekeeper_checker.sv
module slot_gatekeeper_checker #(
  parameter int AW          = 16,
  parameter int IF_W        = 4,
  parameter int TO_W        = 16,
  parameter int DEF_TIMEOUT = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            slotPresent,
  input logic [TO_W-1:0] timeoutLimit,
  input logic            accReq,
  input logic            accReady,
  input logic            accDone,
  input logic            busGrant,
  input logic [AW-1:0]   busAddr,
  input logic [IF_W-1:0] ifEnable,
  input logic [1:0]      slotState,
  input logic            irqMalfunction
);
  logic [TO_W:0] runLen;
  logic [TO_W:0] budget;

  assign budget = (timeoutLimit == '0) ? (TO_W+1)'(DEF_TIMEOUT) : {1'b0, timeoutLimit};

  always_ff @(posedge clk) begin
    if (!rstN)         runLen <= '0;
    else if (busGrant) runLen <= runLen + 1'b1;
    else               runLen <= '0;
  end

  a_r4_if_only_running: assert property (@(posedge clk) disable iff (!rstN)
    (slotState != 2'd2) |-> (ifEnable == '0));
  a_r5_grant_after_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busGrant) |-> $past(accReq));
  a_r5_bus_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busGrant |-> (busAddr == '0));
  a_r7_single_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    accDone |-> !busGrant);
  a_r7_ready_low_in_window: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> !accReady);
  a_r8_window_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> (runLen < budget));
  a_r8_irq_marks_absent: assert property (@(posedge clk) disable iff (!rstN)
    irqMalfunction |-> (slotState == 2'd0) && accDone && $past(busGrant));
  a_r10_presence_loss: assert property (@(posedge clk) disable iff (!rstN)
    !slotPresent |=> !busGrant && (slotState == 2'd0));
endmodule

bind slot_gatekeeper slot_gatekeeper_checker #(
  .AW(AW), .IF_W(IF_W), .TO_W(TO_W), .DEF_TIMEOUT(DEF_TIMEOUT)
) u_checker (
  .clk(clk), .rstN(rstN), .slotPresent(slotPresent), .timeoutLimit(timeoutLimit),
  .accReq(accReq), .accReady(accReady), .accDone(accDone), .busGrant(busGrant),
  .busAddr(busAddr), .ifEnable(ifEnable), .slotState(slotState),
  .irqMalfunction(irqMalfunction)
);

// File: tb/slot_gatekeeper_bench.sv
module slot_gatekeeper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 32, IF_W = 4, TO_W = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            slotPresent = 1'b0;
  logic [TO_W-1:0] timeoutLimit = '0;
  logic            cmdValid = 1'b0;
  logic [1:0]      cmdTarget = '0;
  logic [IF_W-1:0] reqIfMask = 4'b1011;
  logic            accReq = 1'b0, accWe = 1'b0;
  logic [AW-1:0]   accAddr = '0;
  logic [DW-1:0]   accWdata = '0;
  logic            accReady, accDone, busGrant, busWe, irqMalfunction;
  logic [DW-1:0]   accRdata, busWdata;
  logic [AW-1:0]   busAddr;
  logic            slotDone = 1'b0;
  logic [DW-1:0]   slotRdata = '0;
  logic [IF_W-1:0] ifEnable;
  logic [1:0]      slotState;

  int nChecks = 0, nFails = 0, cycles = 0;
  logic [1:0] mState = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_gatekeeper u_slot_gatekeeper (
    .clk(clk), .rstN(rstN), .slotPresent(slotPresent), .timeoutLimit(timeoutLimit),
    .cmdValid(cmdValid), .cmdTarget(cmdTarget), .reqIfMask(reqIfMask),
    .accReq(accReq), .accWe(accWe), .accAddr(accAddr), .accWdata(accWdata),
    .accReady(accReady), .accDone(accDone), .accRdata(accRdata), .busGrant(busGrant),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata), .slotDone(slotDone),
    .slotRdata(slotRdata), .ifEnable(ifEnable), .slotState(slotState),
    .irqMalfunction(irqMalfunction)
  );

  function automatic logic [1:0] nextState(logic [1:0] cur, logic [1:0] tgt);
    if (cur == 2'd1 && tgt == 2'd2) return tgt;
    if (cur == 2'd2 && (tgt == 2'd1 || tgt == 2'd3)) return tgt;
    if (cur == 2'd3 && tgt == 2'd2) return tgt;
    return cur;
  endfunction

  function automatic int effLimit(logic [TO_W-1:0] lim);
    return (lim == 0) ? 64 : int'(lim);
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic checkState(input string tag);
    chk(slotState == mState, tag, slotState, mState);
    chk(ifEnable == ((mState == 2'd2) ? reqIfMask : '0), "R4 ifEnable", ifEnable,
        (mState == 2'd2) ? reqIfMask : '0);
  endtask

  task automatic command(input logic [1:0] tgt);
    @(negedge clk);
    cmdValid = 1'b1; cmdTarget = tgt;
    @(negedge clk);
    cmdValid = 1'b0;
    mState = nextState(mState, tgt);
    checkState("R3 command");
  endtask

  task automatic rePresent();
    @(negedge clk); slotPresent = 1'b0;
    @(negedge clk); slotPresent = 1'b1;
    @(negedge clk);
    mState = 2'd1;
    checkState("R2 presence rise");
  endtask

  // one access; delay = grant cycle index in which the slot raises done
  task automatic access(input logic we, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        input int delay, input logic [DW-1:0] resp);
    int lim = effLimit(timeoutLimit);
    int gCycles = 0, guard = 0;
    logic got = 1'b0, sawIrq = 1'b0;
    logic [DW-1:0] rd = '0;
    int expCycles;
    logic [DW-1:0] expRd;
    logic expIrq;
    if (mState == 2'd0) begin expCycles = 0; expRd = '1; expIrq = 1'b0; end
    else if (delay < lim) begin expCycles = delay + 1; expRd = resp; expIrq = 1'b0; end
    else begin expCycles = lim; expRd = '1; expIrq = 1'b1; end
    @(negedge clk);
    chk(accReady, "R7 ready when idle", accReady, 1);
    accReq = 1'b1; accWe = we; accAddr = addr; accWdata = wd;
    while (!got && guard < 2000) begin
      @(negedge clk);
      guard++;
      accReq = 1'b0;
      slotDone = 1'b0;
      if (accDone) begin
        got = 1'b1; rd = accRdata; sawIrq = irqMalfunction;
        chk(!busGrant && busAddr == '0, "R5 bus quiet after close", busAddr, 0);
      end else if (busGrant) begin
        if (gCycles == 0) begin
          chk(busAddr == addr && busWdata == wd && busWe == we, "R5 bus carries request",
              busAddr, addr);
          chk(!accReady, "R7 ready low in window", accReady, 0);
        end
        if (gCycles == delay) begin slotDone = 1'b1; slotRdata = resp; end
        gCycles++;
      end
    end
    chk(gCycles == expCycles, "R6/R8/R9/R11 grant cycles", gCycles, expCycles);
    chk(rd == expRd, "R6/R8/R11 read data", rd, expRd);
    chk(sawIrq == expIrq, "R8 malfunction irq", sawIrq, expIrq);
    if (expIrq) mState = 2'd0;
    checkState("R8 state after access");
    @(negedge clk);
    chk(!accDone && !irqMalfunction, "R6 R8 single pulse", {accDone, irqMalfunction}, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog expired");
        finishRun();
      end
    end
  end

  initial begin
    void'($urandom(32'h5107_A11D));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(slotState == 2'd0 && !busGrant && !accDone && !irqMalfunction && ifEnable == '0,
        "R1 reset state", {slotState, busGrant, accDone, irqMalfunction}, 0);
    // R11 access while absent
    access(1'b0, 16'h0010, 32'h0, 3, 32'h1234_5678);
    // R2 presence
    slotPresent = 1'b1;
    @(negedge clk);
    mState = 2'd1;
    checkState("R2 newly present");
    // R5 R6 in Config, read and write
    access(1'b0, 16'h0004, 32'h0, 2, 32'hCAFE_0001);
    access(1'b1, 16'h0008, 32'hDEAD_BEEF, 0, 32'h0000_0042);
    // R3 illegal and legal moves
    command(2'd3);
    command(2'd0);
    command(2'd2);
    command(2'd3);
    command(2'd1);
    command(2'd2);
    command(2'd2);
    command(2'd1);
    // R9 default budget, last cycle before expiry, then R8 expiry
    timeoutLimit = '0;
    access(1'b0, 16'h0020, 32'h0, 63, 32'h0BAD_F00D);
    access(1'b0, 16'h0024, 32'h0, 70, 32'h0BAD_F00D);
    access(1'b0, 16'h0028, 32'h0, 1, 32'h5555_AAAA);
    command(2'd2);
    rePresent();
    // R10 presence loss mid-window
    @(negedge clk);
    accReq = 1'b1; accAddr = 16'h0030; accWe = 1'b0;
    @(negedge clk); accReq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(busGrant, "R10 window open before loss", busGrant, 1);
    slotPresent = 1'b0;
    @(negedge clk);
    mState = 2'd0;
    chk(!busGrant && accDone && accRdata == '1 && !irqMalfunction, "R10 abort on loss",
        {busGrant, accDone, irqMalfunction}, 3'b010);
    checkState("R10 state absent");
    slotPresent = 1'b1;
    @(negedge clk);
    mState = 2'd1;
    checkState("R2 present again");
    // random mix
    for (int i = 0; i < 80; i++) begin
      if ($urandom_range(0, 2) == 0) begin
        command(2'($urandom_range(0, 3)));
      end else begin
        timeoutLimit = TO_W'($urandom_range(1, 8));
        access(1'($urandom_range(0, 1)), AW'($urandom), $urandom,
               $urandom_range(0, 10), $urandom);
        if (mState == 2'd0) rePresent();
      end
    end
    finishRun();
  end
endmodule